// File: doc/BRIEF.md
# Count/Compare Timer with Routed Interrupt

The block pairs a free-running 32-bit counter with a 32-bit comparison register. The counter advances by one on each enabled tick. When the counter takes a value equal to the comparison register, the block latches a pending timer interrupt. It drives that interrupt onto one of eight output lines, chosen by a 3-bit routing field. Software loads either register through a write strobe and a data word. A write to the comparison register is the acknowledge: it withdraws the pending interrupt.

A freeze input stops the counter and suppresses matches. The counter can still be loaded while frozen. A feature flag turns on a sticky timer-interrupt status bit, which follows the pending interrupt. With the flag low, the block drives only the interrupt line and leaves the status bit alone.

Top module: `tick_cmp_timer`

## Requirements
- R1: After reset the counter reads 1, the comparison register reads 0, the status bit is 0 and all eight interrupt lines are 0.
- R2: With `tick_en` high, `cnt_hold` low and no counter write, the counter increments by one per clock and wraps from 0xFFFFFFFF to 0. With `tick_en` low it keeps its value.
- R3: A counter write loads `cnt_wdata` on that clock edge and takes priority over the increment. Counting resumes from the loaded value.
- R4: A comparison write loads `cmp_wdata` on that clock edge.
- R5: A counter update (increment or write) that makes the counter equal to the comparison register sets the interrupt pending on that edge. The interrupt stays pending after the counter moves past the match, until the comparison register is written.
- R6: While `cnt_hold` is 1, the counter does not increment and no match sets the interrupt, even when a counter write makes the counter equal to the comparison register. Counter writes still take effect.
- R7: A comparison write clears the pending interrupt on that edge. If a match occurs in the same cycle, the write wins and the interrupt stays clear.
- R8: With `rel2_en` at 1, a match sets `ti_flag` and a comparison write clears it. With `rel2_en` at 0, `ti_flag` keeps its value.
- R9: `irq_vec` is all zero when no interrupt is pending. Otherwise only bit `irq_sel` (value 0 to 7 selects bit 0 to 7) is 1. A change of `irq_sel` moves the pending interrupt to the new line in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Counter advance enable |
| cnt_we | input | 1 | Counter write strobe |
| cnt_wdata | input | 32 | Counter write value |
| cmp_we | input | 1 | Comparison write strobe (also acknowledges the interrupt) |
| cmp_wdata | input | 32 | Comparison write value |
| cnt_hold | input | 1 | Freeze counter and suppress matches |
| irq_sel | input | 3 | Interrupt line selection |
| rel2_en | input | 1 | Enables the timer status bit |
| cnt_val | output | 32 | Current counter value |
| cmp_val | output | 32 | Current comparison value |
| ti_flag | output | 1 | Timer interrupt status bit |
| irq_vec | output | 8 | Interrupt lines, at most one high |

## Verification
Counter, comparison value, pending state and status bit all change on the clock edge that samples the stimulus. Each result is therefore due exactly one edge after the inputs are applied. The routing of `irq_vec` is the one exception: it follows `irq_sel` without a register. The bench drives inputs between edges and advances one edge per step. It compares every output 1 ns after that edge against a model stepped with the same inputs, so a late or early change of any register shows up in the very step where it is due. Directed steps cover wrap, simultaneous acknowledge and match, freeze with an equal load, reroute while pending and the feature flag off. Random steps then place the comparison value a few ticks ahead of the counter to produce frequent matches.

// File: rtl/tick_cmp_pkg.sv
package tick_cmp_pkg;

    localparam int unsigned CNT_W = 32;
    localparam int unsigned SEL_W = 3;
    localparam int unsigned LINES = 1 << SEL_W;

    typedef logic [CNT_W-1:0] word_t;
    typedef logic [SEL_W-1:0] sel_t;
    typedef logic [LINES-1:0] lines_t;

    localparam word_t CNT_RST = word_t'(1);
    localparam word_t CMP_RST = word_t'(0);

    typedef struct packed {
        logic pend;
        logic ti;
    } irq_state_t;

    // Acknowledge dominates a simultaneous match; status moves only with the feature flag.
    function automatic irq_state_t irq_next(irq_state_t cur, logic hit, logic ack, logic rel2);
        irq_state_t nxt;
        nxt = cur;
        if (ack)      nxt.pend = 1'b0;
        else if (hit) nxt.pend = 1'b1;
        if (rel2) begin
            if (ack)      nxt.ti = 1'b0;
            else if (hit) nxt.ti = 1'b1;
        end
        return nxt;
    endfunction

endpackage

// File: rtl/tc_counter.sv
module tc_counter
    import tick_cmp_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  tick_en,
    input  logic  hold,
    input  logic  we,
    input  word_t wdata,
    input  word_t cmp_q,
    output word_t cnt_q,
    output logic  hit
);

    logic  advance;
    word_t cnt_d;

    always_comb begin
        advance = tick_en && !hold;
        if (we)           cnt_d = wdata;
        else if (advance) cnt_d = cnt_q + word_t'(1);
        else              cnt_d = cnt_q;
        hit = !hold && (we || advance) && (cnt_d == cmp_q);
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= CNT_RST;
        else     cnt_q <= cnt_d;
    end

endmodule

// File: rtl/tc_compare.sv
module tc_compare
    import tick_cmp_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  we,
    input  word_t wdata,
    output word_t cmp_q
);

    always_ff @(posedge clk) begin
        if (rst)     cmp_q <= CMP_RST;
        else if (we) cmp_q <= wdata;
    end

endmodule

// File: rtl/tc_irq.sv
module tc_irq
    import tick_cmp_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   hit,
    input  logic   ack,
    input  logic   rel2,
    input  sel_t   sel,
    output logic   ti,
    output lines_t vec
);

    irq_state_t st_q;

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= irq_next(st_q, hit, ack, rel2);
    end

    assign ti = st_q.ti;

    for (genvar i = 0; i < LINES; i++) begin : g_line
        assign vec[i] = st_q.pend && (sel == sel_t'(i));
    end

endmodule

// File: rtl/tick_cmp_timer.sv
module tick_cmp_timer
    import tick_cmp_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        tick_en,
    input  logic        cnt_we,
    input  logic [31:0] cnt_wdata,
    input  logic        cmp_we,
    input  logic [31:0] cmp_wdata,
    input  logic        cnt_hold,
    input  logic [2:0]  irq_sel,
    input  logic        rel2_en,
    output logic [31:0] cnt_val,
    output logic [31:0] cmp_val,
    output logic        ti_flag,
    output logic [7:0]  irq_vec
);

    word_t cmp_q;
    word_t cnt_q;
    logic  hit;

    tc_compare u_cmp (
        .clk   (clk),
        .rst   (rst),
        .we    (cmp_we),
        .wdata (cmp_wdata),
        .cmp_q (cmp_q)
    );

    tc_counter u_cnt (
        .clk     (clk),
        .rst     (rst),
        .tick_en (tick_en),
        .hold    (cnt_hold),
        .we      (cnt_we),
        .wdata   (cnt_wdata),
        .cmp_q   (cmp_q),
        .cnt_q   (cnt_q),
        .hit     (hit)
    );

    tc_irq u_irq (
        .clk  (clk),
        .rst  (rst),
        .hit  (hit),
        .ack  (cmp_we),
        .rel2 (rel2_en),
        .sel  (irq_sel),
        .ti   (ti_flag),
        .vec  (irq_vec)
    );

    assign cnt_val = cnt_q;
    assign cmp_val = cmp_q;

endmodule

// File: rtl/tc_timer_chk.sv
module tc_timer_chk (
    input logic        clk,
    input logic        rst,
    input logic        tick_en,
    input logic        cnt_we,
    input logic [31:0] cnt_wdata,
    input logic        cmp_we,
    input logic [31:0] cmp_wdata,
    input logic        cnt_hold,
    input logic [2:0]  irq_sel,
    input logic        rel2_en,
    input logic [31:0] cnt_val,
    input logic [31:0] cmp_val,
    input logic        ti_flag,
    input logic [7:0]  irq_vec
);

    p_reset_vals_r1: assert property (@(posedge clk)
        rst |=> (cnt_val == 32'd1 && cmp_val == 32'd0 && !ti_flag && irq_vec == 8'd0));

    p_count_step_r2: assert property (@(posedge clk) disable iff (rst)
        (!cnt_we && tick_en && !cnt_hold) |=> (cnt_val == $past(cnt_val) + 32'd1));

    p_count_load_r3: assert property (@(posedge clk) disable iff (rst)
        cnt_we |=> (cnt_val == $past(cnt_wdata)));

    p_cmp_load_r4: assert property (@(posedge clk) disable iff (rst)
        cmp_we |=> (cmp_val == $past(cmp_wdata)));

    p_frozen_still_r6: assert property (@(posedge clk) disable iff (rst)
        (!cnt_we && cnt_hold) |=> $stable(cnt_val));

    p_frozen_noirq_r6: assert property (@(posedge clk) disable iff (rst)
        (cnt_hold && irq_vec == 8'd0) |=> (irq_vec == 8'd0));

    p_ack_clears_r7: assert property (@(posedge clk) disable iff (rst)
        cmp_we |=> (irq_vec == 8'd0));

    p_ti_gated_r8: assert property (@(posedge clk) disable iff (rst)
        !rel2_en |=> $stable(ti_flag));

    p_one_line_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(irq_vec));

endmodule

bind tick_cmp_timer tc_timer_chk i_chk (.*);

// File: tb/test_tick_cmp_timer.sv
module test_tick_cmp_timer;

    logic        clk = 1'b0;
    logic        rst;
    logic        tick_en, cnt_we, cmp_we, cnt_hold, rel2_en;
    logic [31:0] cnt_wdata, cmp_wdata;
    logic [2:0]  irq_sel;
    logic [31:0] cnt_val, cmp_val;
    logic        ti_flag;
    logic [7:0]  irq_vec;

    int n_chk = 0;
    int n_bad = 0;

    logic [31:0] m_cnt, m_cmp;
    logic        m_pend, m_ti;

    always #4 clk = ~clk;

    tick_cmp_timer i_tick_cmp_timer (.*);

    function automatic logic [7:0] exp_vec(logic p, logic [2:0] s);
        return p ? (8'd1 << s) : 8'd0;
    endfunction

    task automatic chk32(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        chk32(tag, "cnt_val", cnt_val, m_cnt);
        chk32(tag, "cmp_val", cmp_val, m_cmp);
        chk32(tag, "ti_flag", {31'd0, ti_flag}, {31'd0, m_ti});
        chk32(tag, "irq_vec", {24'd0, irq_vec}, {24'd0, exp_vec(m_pend, irq_sel)});
    endtask

    // Apply one cycle of stimulus, advance the model, sample 1 ns after the edge.
    task automatic step(string tag, logic tk, logic cw, logic [31:0] cd,
                        logic mw, logic [31:0] md, logic hd, logic [2:0] sl, logic r2);
        logic [31:0] nc;
        logic        hit;
        tick_en = tk; cnt_we = cw; cnt_wdata = cd; cmp_we = mw; cmp_wdata = md;
        cnt_hold = hd; irq_sel = sl; rel2_en = r2;
        nc  = cw ? cd : ((tk && !hd) ? m_cnt + 32'd1 : m_cnt);
        hit = !hd && (cw || (tk && !hd)) && (nc == m_cmp);
        @(posedge clk);
        #1;
        if (r2) m_ti = mw ? 1'b0 : (hit ? 1'b1 : m_ti);
        m_pend = mw ? 1'b0 : (hit ? 1'b1 : m_pend);
        m_cnt  = nc;
        if (mw) m_cmp = md;
        check_all(tag);
    endtask

    initial begin
        #1_000_000;
        n_bad++;
        n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        int seed;
        seed = 32'h5eed_7a11;
        void'($urandom(seed));
        rst = 1'b1; tick_en = 0; cnt_we = 0; cmp_we = 0; cnt_hold = 0;
        cnt_wdata = 0; cmp_wdata = 0; irq_sel = 0; rel2_en = 1;
        repeat (2) @(posedge clk);
        #1;
        rst = 1'b0;
        m_cnt = 32'd1; m_cmp = 32'd0; m_pend = 0; m_ti = 0;
        check_all("R1");

        // R2 counting and idle
        step("R2", 1, 0, 0, 0, 0, 0, 0, 1);
        step("R2", 1, 0, 0, 0, 0, 0, 0, 1);
        step("R2", 0, 0, 0, 0, 0, 0, 0, 1);
        // R3 load, then wrap R2
        step("R3", 1, 1, 32'hFFFF_FFFE, 1, 32'h0000_0100, 0, 0, 1);
        step("R2", 1, 0, 0, 0, 0, 0, 0, 1);
        step("R2", 1, 0, 0, 0, 0, 0, 0, 1);
        chk32("R2", "wrap", cnt_val, 32'd0);
        // R4/R5 match on bit 5, stays after passing
        step("R4", 0, 1, 32'd8, 1, 32'd10, 0, 5, 1);
        step("R5", 1, 0, 0, 0, 0, 0, 5, 1);
        step("R5", 1, 0, 0, 0, 0, 0, 5, 1);
        chk32("R5", "irq line 5", {24'd0, irq_vec}, 32'h20);
        chk32("R8", "ti set", {31'd0, ti_flag}, 32'd1);
        step("R5", 1, 0, 0, 0, 0, 0, 5, 1);
        step("R5", 1, 0, 0, 0, 0, 0, 5, 1);
        // R9 reroute while pending
        #2 irq_sel = 3'd7;
        #1 chk32("R9", "reroute", {24'd0, irq_vec}, 32'h80);
        step("R9", 0, 0, 0, 0, 0, 0, 0, 1);
        // R7 ack
        step("R7", 0, 0, 0, 1, 32'd50, 0, 0, 1);
        chk32("R7", "ack", {24'd0, irq_vec}, 32'd0);
        chk32("R8", "ti clear", {31'd0, ti_flag}, 32'd0);
        // R7 match and ack same cycle
        step("R7", 0, 1, 32'd49, 0, 0, 0, 2, 1);
        step("R7", 1, 0, 0, 1, 32'd50, 0, 2, 1);
        chk32("R7", "collide", {24'd0, irq_vec}, 32'd0);
        // R6 frozen: no step, equal load gives no irq
        step("R6", 1, 0, 0, 0, 0, 1, 2, 1);
        step("R6", 1, 1, 32'd50, 0, 0, 1, 2, 1);
        chk32("R6", "frozen load", cnt_val, 32'd50);
        chk32("R6", "frozen irq", {24'd0, irq_vec}, 32'd0);
        step("R6", 1, 0, 0, 0, 0, 1, 2, 1);
        // R8 feature off: line rises, status stays
        step("R8", 0, 1, 32'd99, 1, 32'd100, 0, 1, 0);
        step("R8", 1, 0, 0, 0, 0, 0, 1, 0);
        chk32("R8", "ti off", {31'd0, ti_flag}, 32'd0);
        chk32("R5", "line 1", {24'd0, irq_vec}, 32'h02);

        // Random phase
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r;
            logic        cw, mw;
            logic [31:0] cd, md;
            r  = $urandom;
            cw = (r[3:0] == 0);
            mw = (r[7:4] == 0);
            cd = (r[8]) ? $urandom : m_cmp - {29'd0, r[11:9]};
            md = m_cnt + {28'd0, r[15:12]};
            step("R5", r[16] | r[17], cw, cd, mw, md, (r[20:18] == 0), r[23:21], r[24] | r[25]);
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule